// File: doc/BRIEF.md
# Page Translation Unit with Fault Classification

This block translates virtual addresses for one process in a paged memory system. It holds one page-table entry for every virtual page. Each entry has a resident flag, a frame number, a read-only flag and a modified flag. A request carries a virtual address and a write indication. One cycle later the block returns a valid pulse together with either a physical address or a fault code. The fault code says why the translation failed: the page lies beyond the process address space, the page is not resident, or a write hit a read-only page.

Software loads and evicts entries through a table-update port. When an entry is evicted, the block reports one cycle later whether the departing page was modified, so the paging logic knows whether that page must be written back to backing store. A writable limit register holds the number of pages the process owns and sets the bound for the out-of-range check. The replacement policy, disk transfers and any translation cache live outside this block.

Top module: `page_xlate`

## Requirements
- R1: A request that does not fault returns `rsp_fault` = 0 and `rsp_pa` = {frame number, page offset}. The offset is the low `OFF_W` bits of `req_va`, passed through unchanged.
- R2: `rsp_vld` pulses exactly one cycle after each cycle with `req_vld` high. In any cycle with no response, `rsp_fault` and `rsp_pa` are 0. After reset, `rsp_vld`, `rsp_pa` and `ev_vld` are 0.
- R3: If the page number (the bits of `req_va` above the offset) is greater than or equal to the limit register, the response carries fault code 1 (out of range). This check takes priority over every other check. The limit resets to the total page count and is loaded from `lim_val` when `lim_we` is high.
- R4: A request to an in-range page whose resident flag is clear returns fault code 2 (not resident). Every faulted response drives `rsp_pa` to 0.
- R5: A write to a resident, in-range, read-only page returns fault code 3 (protection) and leaves the modified flag unchanged. A read of the same page translates normally.
- R6: A load (`pte_we`=1, `pte_load`=1) makes the entry resident and stores `pte_frame` and `pte_ro` in it. It also clears the modified flag.
- R7: Only a write that completes with fault code 0 sets the modified flag of its page. Faulted writes and all reads leave the flag unchanged.
- R8: An evict (`pte_we`=1, `pte_load`=0) clears the resident flag. One cycle later `ev_vld` pulses, and `ev_wb` is 1 exactly when the page was resident and modified.
- R9: A request is checked against the table contents from before any update made in the same cycle. A successful write in the same cycle as an evict of that page gives `ev_wb`=1. A successful write in the same cycle as a load of that page leaves the modified flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Translation request strobe |
| req_wr | input | 1 | Request is a write |
| req_va | input | VA_W | Virtual address |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | 0 ok, 1 out of range, 2 not resident, 3 protection |
| rsp_pa | output | FRAME_W+OFF_W | Physical address, 0 on a fault |
| lim_we | input | 1 | Write enable for the page-count limit |
| lim_val | input | VA_W-OFF_W+1 | New page-count limit |
| pte_we | input | 1 | Table update strobe |
| pte_load | input | 1 | 1 load entry, 0 evict entry |
| pte_page | input | VA_W-OFF_W | Page number being updated |
| pte_frame | input | FRAME_W | Frame number for a load |
| pte_ro | input | 1 | Read-only flag for a load |
| ev_vld | output | 1 | Eviction report strobe |
| ev_wb | output | 1 | Evicted page needs write-back |

## Verification
The modified flag cannot be read directly. It shows only through `ev_wb` when a page is evicted, so each write's effect has to be observed indirectly. The bench first writes every page under a shortened limit, so that writes fail with out-of-range faults, protection faults and successful completions. It then raises the limit and evicts every page, and compares each `ev_wb` against a reference model of the modified flags. The same-cycle races use a dedicated task that issues a request and a table update together. The resulting modified state is then checked through a later eviction.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RANGE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PROT   = 2'd3
  } fault_e;
endpackage

// File: rtl/pgx_limit.sv
module pgx_limit #(
  parameter int PN_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_we,
  input  logic [PN_W:0] lim_val,
  input  logic [PN_W-1:0] page,
  output logic          in_range,
  output logic [PN_W:0] lim
);
  localparam logic [PN_W:0] LIM_RST = (PN_W+1)'(1) << PN_W;

  logic [PN_W:0] lim_q, lim_d;

  always_comb begin
    lim_d = lim_q;
    if (lim_we) lim_d = lim_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lim_q <= LIM_RST;
    else if (lim_we) lim_q <= lim_d;
  end

  assign in_range = ({1'b0, page} < lim_q);
  assign lim      = lim_q;
endmodule

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PN_W    = 6,
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PN_W-1:0]    look_page,
  input  logic               wr_commit,
  input  logic               upd_we,
  input  logic               upd_load,
  input  logic [PN_W-1:0]    upd_page,
  input  logic [FRAME_W-1:0] upd_frame,
  input  logic               upd_ro,
  output logic               look_valid,
  output logic               look_ro,
  output logic [FRAME_W-1:0] look_frame,
  output logic               ev_vld,
  output logic               ev_wb
);
  localparam int NPG = 1 << PN_W;

  logic [NPG-1:0]     v_vec, ro_vec, d_vec;
  logic [FRAME_W-1:0] fr_vec [NPG];

  for (genvar g = 0; g < NPG; g++) begin : g_ent
    logic               v_q, v_d, ro_q, ro_d, d_q, d_d;
    logic [FRAME_W-1:0] fr_q, fr_d;
    logic               hit_wr, hit_upd, en;

    assign hit_wr  = wr_commit && (look_page == PN_W'(g));
    assign hit_upd = upd_we && (upd_page == PN_W'(g));
    assign en      = hit_wr || hit_upd;

    always_comb begin
      v_d  = v_q;
      ro_d = ro_q;
      d_d  = d_q;
      fr_d = fr_q;
      if (hit_wr) d_d = 1'b1;
      if (hit_upd) begin
        if (upd_load) begin
          v_d  = 1'b1;
          ro_d = upd_ro;
          d_d  = 1'b0;
          fr_d = upd_frame;
        end else begin
          v_d = 1'b0;
          d_d = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        ro_q <= 1'b0;
        d_q  <= 1'b0;
      end else if (en) begin
        v_q  <= v_d;
        ro_q <= ro_d;
        d_q  <= d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (en) fr_q <= fr_d;
    end

    assign v_vec[g]  = v_q;
    assign ro_vec[g] = ro_q;
    assign d_vec[g]  = d_q;
    assign fr_vec[g] = fr_q;
  end

  assign look_valid = v_vec[look_page];
  assign look_ro    = ro_vec[look_page];
  assign look_frame = fr_vec[look_page];

  logic ev_vld_d, ev_wb_d;

  always_comb begin
    ev_vld_d = upd_we && !upd_load;
    ev_wb_d  = ev_vld_d && v_vec[upd_page] &&
               (d_vec[upd_page] || (wr_commit && (look_page == upd_page)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_vld <= 1'b0;
      ev_wb  <= 1'b0;
    end else begin
      ev_vld <= ev_vld_d;
      ev_wb  <= ev_wb_d;
    end
  end
endmodule

// File: rtl/pgx_resp.sv
module pgx_resp
  import pgx_pkg::*;
#(
  parameter int FRAME_W = 4,
  parameter int OFF_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_vld,
  input  logic                     req_wr,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     in_range,
  input  logic                     look_valid,
  input  logic                     look_ro,
  input  logic [FRAME_W-1:0]       look_frame,
  output logic                     wr_commit,
  output logic                     rsp_vld,
  output logic [1:0]               rsp_fault,
  output logic [FRAME_W+OFF_W-1:0] rsp_pa
);
  localparam int PA_W = FRAME_W + OFF_W;

  fault_e              cause;
  logic                vld_d;
  logic [1:0]          flt_d;
  logic [PA_W-1:0]     pa_d;

  always_comb begin
    if (!in_range)              cause = FLT_RANGE;
    else if (!look_valid)       cause = FLT_ABSENT;
    else if (req_wr && look_ro) cause = FLT_PROT;
    else                        cause = FLT_NONE;
  end

  assign wr_commit = req_vld && req_wr && (cause == FLT_NONE);

  always_comb begin
    vld_d = req_vld;
    flt_d = req_vld ? cause : FLT_NONE;
    pa_d  = '0;
    if (req_vld && (cause == FLT_NONE)) pa_d = {look_frame, req_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_fault <= 2'd0;
      rsp_pa    <= '0;
    end else begin
      rsp_vld   <= vld_d;
      rsp_fault <= flt_d;
      rsp_pa    <= pa_d;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W    = 10,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_vld,
  input  logic                       req_wr,
  input  logic [VA_W-1:0]            req_va,
  output logic                       rsp_vld,
  output logic [1:0]                 rsp_fault,
  output logic [FRAME_W+OFF_W-1:0]   rsp_pa,
  input  logic                       lim_we,
  input  logic [VA_W-OFF_W:0]        lim_val,
  input  logic                       pte_we,
  input  logic                       pte_load,
  input  logic [VA_W-OFF_W-1:0]      pte_page,
  input  logic [FRAME_W-1:0]         pte_frame,
  input  logic                       pte_ro,
  output logic                       ev_vld,
  output logic                       ev_wb
);
  localparam int PN_W = VA_W - OFF_W;

  logic [PN_W-1:0]    req_page;
  logic [OFF_W-1:0]   req_off;
  logic               in_range;
  logic [PN_W:0]      lim;
  logic               look_valid, look_ro, wr_commit;
  logic [FRAME_W-1:0] look_frame;

  assign req_page = req_va[VA_W-1:OFF_W];
  assign req_off  = req_va[OFF_W-1:0];

  pgx_limit #(.PN_W(PN_W)) u_lim (
    .clk      (clk),
    .rst_n    (rst_n),
    .lim_we   (lim_we),
    .lim_val  (lim_val),
    .page     (req_page),
    .in_range (in_range),
    .lim      (lim)
  );

  pgx_table #(.PN_W(PN_W), .FRAME_W(FRAME_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .look_page  (req_page),
    .wr_commit  (wr_commit),
    .upd_we     (pte_we),
    .upd_load   (pte_load),
    .upd_page   (pte_page),
    .upd_frame  (pte_frame),
    .upd_ro     (pte_ro),
    .look_valid (look_valid),
    .look_ro    (look_ro),
    .look_frame (look_frame),
    .ev_vld     (ev_vld),
    .ev_wb      (ev_wb)
  );

  pgx_resp #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_wr     (req_wr),
    .req_off    (req_off),
    .in_range   (in_range),
    .look_valid (look_valid),
    .look_ro    (look_ro),
    .look_frame (look_frame),
    .wr_commit  (wr_commit),
    .rsp_vld    (rsp_vld),
    .rsp_fault  (rsp_fault),
    .rsp_pa     (rsp_pa)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int VA_W    = 10,
  parameter int OFF_W   = 4,
  parameter int FRAME_W = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_vld,
  input logic [VA_W-1:0]          req_va,
  input logic                     rsp_vld,
  input logic [1:0]               rsp_fault,
  input logic [FRAME_W+OFF_W-1:0] rsp_pa,
  input logic                     pte_we,
  input logic                     pte_load,
  input logic                     ev_vld,
  input logic                     ev_wb,
  input logic [VA_W-OFF_W:0]      lim
);
  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_vld == $past(req_vld)));

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (rsp_fault == 2'd0 && rsp_pa == '0));

  // R4
  fault_pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_fault != 2'd0) |-> (rsp_pa == '0));

  // R3
  range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_vld) &&
     $past({1'b0, req_va[VA_W-1:OFF_W]} >= lim)) |-> (rsp_fault == 2'd1));

  // R8
  evict_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (ev_vld == $past(pte_we && !pte_load)));

  // R8
  wb_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb |-> ev_vld);
endmodule

bind page_xlate page_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_va    (req_va),
  .rsp_vld   (rsp_vld),
  .rsp_fault (rsp_fault),
  .rsp_pa    (rsp_pa),
  .pte_we    (pte_we),
  .pte_load  (pte_load),
  .ev_vld    (ev_vld),
  .ev_wb     (ev_wb),
  .lim       (lim)
);

// File: tb/page_xlate_test.sv
module page_xlate_test;
  localparam int VA_W = 10, OFF_W = 4, FRAME_W = 4;
  localparam int PN_W = VA_W - OFF_W;
  localparam int NPG  = 1 << PN_W;
  localparam int PA_W = FRAME_W + OFF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic req_vld, req_wr;
  logic [VA_W-1:0] req_va;
  logic rsp_vld;
  logic [1:0] rsp_fault;
  logic [PA_W-1:0] rsp_pa;
  logic lim_we;
  logic [PN_W:0] lim_val;
  logic pte_we, pte_load, pte_ro;
  logic [PN_W-1:0] pte_page;
  logic [FRAME_W-1:0] pte_frame;
  logic ev_vld, ev_wb;

  page_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr), .req_va(req_va),
    .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .lim_we(lim_we), .lim_val(lim_val), .pte_we(pte_we), .pte_load(pte_load),
    .pte_page(pte_page), .pte_frame(pte_frame), .pte_ro(pte_ro),
    .ev_vld(ev_vld), .ev_wb(ev_wb)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit mv [NPG];
  bit mro[NPG];
  bit md [NPG];
  int mf [NPG];
  int mlim;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_fault(input int page, input bit wr);
    if (page >= mlim) return 1;
    if (!mv[page]) return 2;
    if (wr && mro[page]) return 3;
    return 0;
  endfunction

  function automatic string tag_of(input int f);
    case (f)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // op: 0 none, 1 load (frame nf, writable), 2 evict; all on the requested page
  task automatic xact(input int page, input int off, input bit wr, input int op, input int nf);
    int ef, epa;
    bit ewb;
    ef  = exp_fault(page, wr);
    epa = (ef == 0) ? (mf[page] * (1 << OFF_W) + off) : 0;
    ewb = mv[page] && (md[page] || (ef == 0 && wr));
    @(negedge clk);
    req_vld = 1'b1;
    req_wr  = wr;
    req_va  = {page[PN_W-1:0], off[OFF_W-1:0]};
    if (op != 0) begin
      pte_we    = 1'b1;
      pte_load  = (op == 1);
      pte_page  = page[PN_W-1:0];
      pte_frame = nf[FRAME_W-1:0];
      pte_ro    = 1'b0;
    end
    @(negedge clk);
    check(rsp_vld == 1'b1, "R2 rsp_vld", int'(rsp_vld), 1);
    check(int'(rsp_fault) == ef, tag_of(ef), int'(rsp_fault), ef);
    check(int'(rsp_pa) == epa, (ef == 0) ? "R1 pa" : "R4 pa", int'(rsp_pa), epa);
    if (op == 2) begin
      check(ev_vld == 1'b1, "R9 ev_vld", int'(ev_vld), 1);
      check(ev_wb == ewb, "R9 ev_wb", int'(ev_wb), int'(ewb));
    end
    req_vld = 1'b0;
    req_wr  = 1'b0;
    pte_we  = 1'b0;
    if (ef == 0 && wr) md[page] = 1'b1;
    if (op == 1) begin mv[page] = 1; mro[page] = 0; md[page] = 0; mf[page] = nf; end
    if (op == 2) begin mv[page] = 0; md[page] = 0; end
  endtask

  task automatic req(input int page, input int off, input bit wr);
    xact(page, off, wr, 0, 0);
  endtask

  task automatic load(input int page, input int fr, input bit ro);
    @(negedge clk);
    pte_we = 1'b1; pte_load = 1'b1; pte_page = page[PN_W-1:0];
    pte_frame = fr[FRAME_W-1:0]; pte_ro = ro;
    @(negedge clk);
    pte_we = 1'b0;
    check(ev_vld == 1'b0, "R6 no report on load", int'(ev_vld), 0);
    mv[page] = 1; mro[page] = ro; md[page] = 0; mf[page] = fr;
  endtask

  task automatic evict(input int page);
    bit ewb;
    ewb = mv[page] && md[page];
    @(negedge clk);
    pte_we = 1'b1; pte_load = 1'b0; pte_page = page[PN_W-1:0];
    @(negedge clk);
    pte_we = 1'b0;
    check(ev_vld == 1'b1, "R8 ev_vld", int'(ev_vld), 1);
    check(ev_wb == ewb, "R8 ev_wb", int'(ev_wb), int'(ewb));
    mv[page] = 0; md[page] = 0;
  endtask

  task automatic set_limit(input int v);
    @(negedge clk);
    lim_we = 1'b1; lim_val = v[PN_W:0];
    @(negedge clk);
    lim_we = 1'b0;
    mlim = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_vld = 0; req_wr = 0; req_va = '0;
    lim_we = 0; lim_val = '0; pte_we = 0; pte_load = 0; pte_page = '0;
    pte_frame = '0; pte_ro = 0;
    for (int i = 0; i < NPG; i++) begin mv[i] = 0; mro[i] = 0; md[i] = 0; mf[i] = 0; end
    mlim = NPG;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_vld == 1'b0, "R2 reset rsp_vld", int'(rsp_vld), 0);
    check(rsp_pa == '0, "R2 reset rsp_pa", int'(rsp_pa), 0);
    check(ev_vld == 1'b0, "R2 reset ev_vld", int'(ev_vld), 0);

    // R4 / R3: empty table, default limit covers every page
    for (int p = 0; p < NPG; p++) req(p, (p * 5) % 16, p[0]);
    @(negedge clk);
    check(rsp_vld == 1'b0, "R2 idle", int'(rsp_vld), 0);

    // R6: load every page, every fifth one read-only
    for (int p = 0; p < NPG; p++) load(p, (p * 7 + 3) % 16, (p % 5) == 0);
    for (int p = 0; p < NPG; p++) req(p, (p * 3 + 1) % 16, 1'b0);

    // R3: shortened limit, then writes of every kind (R5, R7)
    set_limit(40);
    for (int p = 0; p < NPG; p++) req(p, p % 16, 1'b0);
    for (int p = 0; p < NPG; p++) req(p, (p + 9) % 16, 1'b1);

    // R8: evict everything and compare modified flags
    set_limit(NPG);
    for (int p = 0; p < NPG; p++) evict(p);
    for (int p = 0; p < NPG; p += 7) req(p, 2, 1'b0);

    // R3 edges: limit 0 and limit above the page count
    set_limit(0);
    req(0, 0, 1'b0);
    req(NPG - 1, 15, 1'b1);
    set_limit(NPG + 20);
    load(NPG - 1, 9, 1'b0);
    req(NPG - 1, 15, 1'b0);

    // R6: reload clears the modified flag
    load(3, 4, 1'b0);
    req(3, 6, 1'b1);
    load(3, 5, 1'b0);
    evict(3);

    // R9: write and evict in the same cycle
    load(8, 2, 1'b0);
    xact(8, 11, 1'b1, 2, 0);
    req(8, 11, 1'b0);
    // R9: write and load in the same cycle, flag ends clear
    load(9, 6, 1'b0);
    xact(9, 1, 1'b1, 1, 12);
    req(9, 1, 1'b0);
    evict(9);
    // R9: faulted write plus evict reports no write-back
    load(10, 1, 1'b1);
    xact(10, 4, 1'b1, 2, 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule